// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Count Order

This block produces the internal word address of a burst-capable synchronous memory. When either of two active-low address strobes is sampled low, the external address is loaded and the burst restarts from its first beat. On later edges, with both strobes idle and the active-low step input asserted, the sequencer moves to the next beat of a four-beat burst. Only the two least significant address bits change. The upper bits keep the value that was loaded.

The count order is chosen at run time by a single mode input. With the mode high, the sequence is interleaved: the low bits equal the starting low bits XOR the beat number. With the mode low, the sequence is linear and wraps inside the aligned four-word block. The mode is sampled on every edge that advances, so changing it in the middle of a burst takes effect on the next step. After the fourth beat, a further step returns to the first address of the burst.

The byte-write strobes count as a write-side advance qualifier. They are ignored on any edge that loads a new address. The memory array, the data path and the output drivers are outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: When `cpu_strobe_n` or `ctl_strobe_n` (or both) is sampled low at a rising edge, `cur_addr` equals the sampled `ext_addr` after that edge, and the beat number restarts at 0.
- R2: On a load edge, `step_n` and `bytewr_n` are ignored: `cur_addr` shows exactly the loaded address, whatever their values.
- R3: With both strobes high and `step_n` high, `cur_addr` holds its value, whatever `bytewr_n` and `order_sel` are.
- R4: With both strobes high and `step_n` low, the beat number advances by one (modulo 4) on each edge. This holds for read-style stepping (all `bytewr_n` bits high) and for write-style stepping (any `bytewr_n` bit low).
- R5: When `order_sel` is 1 on an advancing edge, the new `cur_addr[1:0]` equals start_low XOR beat, where start_low is `ext_addr[1:0]` captured at the load and beat is the new beat number.
- R6: When `order_sel` is 0 on an advancing edge, the new `cur_addr[1:0]` equals (start_low + beat) mod 4.
- R7: After the fourth beat, the next step wraps to the first address of the burst. Stepping never changes `cur_addr[ADDR_W-1:2]`.
- R8: A rising edge with `rst_n` low (synchronous, active low) clears `cur_addr` to 0 and the beat number to 0, so later steps start from start_low 0.
- R9: The byte-write strobes alone never move the address: with `step_n` high they have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_strobe_n | input | 1 | Processor-side address strobe, active low, loads `ext_addr` |
| ctl_strobe_n | input | 1 | Controller-side address strobe, active low, loads `ext_addr` |
| step_n | input | 1 | Advance request, active low, ignored on load edges |
| bytewr_n | input | NUM_BYTES | Byte-write strobes, active low, write-side advance qualifier |
| order_sel | input | 1 | Count order: 1 interleaved (XOR), 0 linear wrap |
| ext_addr | input | ADDR_W | External address to load |
| cur_addr | output | ADDR_W | Current internal burst address |

## Verification
Two functions can fall in the same cycle: a load and a step request. A strobe can be sampled low while `step_n` and a byte-write strobe are also low. The bench provokes this on purpose with directed collisions, and also at random across thousands of cycles. Its behavioural reference model gives the load priority, restarts the beat count, and compares `cur_addr` after every edge. A second clash is a change of `order_sel` in the middle of a burst. The model recomputes the low bits from the captured start and the beat number under the new order. The model does not add to the previous address.

// File: rtl/burst_seq_pkg.sv
// Package: shared types of the burst address sequencer.
// Assumes: the count-order select is a single bit, with 1 meaning interleaved.
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_strobe_decode.sv
// Module: burst_strobe_decode
// Turns the strobe, step and byte-write inputs into two exclusive commands:
// load a new address, or advance the beat.
// Assumes: all inputs are active low and already synchronous to the clock.
module burst_strobe_decode #(
    parameter int NUM_BYTES = 4
) (
    input  logic                 cpu_strobe_n,
    input  logic                 ctl_strobe_n,
    input  logic                 step_n,
    input  logic [NUM_BYTES-1:0] bytewr_n,
    output logic                 load_go,
    output logic                 adv_go
);

    logic strobes_idle;
    logic adv_read;
    logic adv_write;

    // Command decode: a load always wins over any advance request.
    always_comb begin
        strobes_idle = cpu_strobe_n && ctl_strobe_n;
        load_go      = !strobes_idle;
        adv_read     = !step_n && strobes_idle;
        adv_write    = !step_n && !(&bytewr_n);
        adv_go       = !load_go && (adv_read || adv_write);
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Module: burst_beat_ctr
// Keeps the beat number of the current burst. It restarts on a load and
// wraps modulo the burst length on each advance.
// Assumes: the burst length is a power of two, and load and advance are exclusive.
module burst_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_go,
    input  logic              adv_go,
    output logic [BEAT_W-1:0] beat_nxt
);

    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    logic [BEAT_W-1:0] beat_q;

    // Next beat number, used by the address update on an advance edge.
    always_comb begin
        beat_nxt = beat_q + BEAT_ONE;
    end

    // Beat register: cleared by reset or a load, stepped by an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else if (load_go) begin
            beat_q <= '0;
        end else if (adv_go) begin
            beat_q <= beat_nxt;
        end
    end

endmodule

// File: rtl/burst_lane_order.sv
// Module: burst_lane_order
// Maps the start low bits and a beat number to the low address bits, in
// interleaved (XOR) order or in linear wrapping order.
// Assumes: the beat number is already reduced modulo the burst length.
module burst_lane_order
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] lane_lo
);

    // Order select: XOR of the beat, or an add that wraps inside the aligned block.
    always_comb begin
        unique case (order)
            ORD_XOR: lane_lo = start_lo ^ beat;
            default: lane_lo = start_lo + beat;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Internal address generator for a burst synchronous memory. Either strobe
// loads the external address. Later steps walk the low bits through one
// burst in the order chosen by order_sel. The upper bits are held.
// Assumes: BURST_LEN is a power of two and smaller than 2**ADDR_W. Reset is
// synchronous and active low.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W    = 17,
    parameter int BURST_LEN = 4,
    parameter int NUM_BYTES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_strobe_n,
    input  logic                 ctl_strobe_n,
    input  logic                 step_n,
    input  logic [NUM_BYTES-1:0] bytewr_n,
    input  logic                 order_sel,
    input  logic [ADDR_W-1:0]    ext_addr,
    output logic [ADDR_W-1:0]    cur_addr
);

    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam int HI_W   = ADDR_W - BEAT_W;

    logic              load_go;
    logic              adv_go;
    logic [BEAT_W-1:0] beat_nxt;
    logic [BEAT_W-1:0] lane_lo;
    logic [HI_W-1:0]   hi_q;
    logic [BEAT_W-1:0] lo_q;
    logic [BEAT_W-1:0] start_q;
    burst_order_e      order;

    // Cast the raw mode bit to the order type.
    always_comb begin
        order = burst_order_e'(order_sel);
    end

    burst_strobe_decode #(
        .NUM_BYTES (NUM_BYTES)
    ) u_decode (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .step_n       (step_n),
        .bytewr_n     (bytewr_n),
        .load_go      (load_go),
        .adv_go       (adv_go)
    );

    burst_beat_ctr #(
        .BEAT_W (BEAT_W)
    ) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_go  (load_go),
        .adv_go   (adv_go),
        .beat_nxt (beat_nxt)
    );

    burst_lane_order #(
        .BEAT_W (BEAT_W)
    ) u_order (
        .start_lo (start_q),
        .beat     (beat_nxt),
        .order    (order),
        .lane_lo  (lane_lo)
    );

    // Address register: load the whole address, or replace the low bits on an advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            start_q <= '0;
        end else if (load_go) begin
            hi_q    <= ext_addr[ADDR_W-1:BEAT_W];
            lo_q    <= ext_addr[BEAT_W-1:0];
            start_q <= ext_addr[BEAT_W-1:0];
        end else if (adv_go) begin
            lo_q    <= lane_lo;
        end
    end

    // Drive the output from the register halves.
    always_comb begin
        cur_addr = {hi_q, lo_q};
    end

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Property checker for burst_addr_seq, attached by bind. It keeps its own
// record of the start bits and the beat number to judge the count order.
// Assumes: it is bound to the top, with the same address and beat widths.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              step_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] cur_addr
);

    logic [BEAT_W-1:0] chk_start;
    logic [BEAT_W-1:0] chk_beat;
    logic              idle;

    // Strobe-idle shorthand used by several properties.
    always_comb begin
        idle = cpu_strobe_n && ctl_strobe_n;
    end

    // Shadow record of the burst start and beat, built from the ports only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_start <= '0;
            chk_beat  <= '0;
        end else if (!idle) begin
            chk_start <= ext_addr[BEAT_W-1:0];
            chk_beat  <= '0;
        end else if (!step_n) begin
            chk_beat  <= chk_beat + BEAT_W'(1);
        end
    end

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> cur_addr == $past(ext_addr));  // R1

    AST_STEP_IGNORED_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_strobe_n && !step_n) |=> cur_addr == $past(ext_addr));  // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && step_n) |=> $stable(cur_addr));  // R3

    AST_XOR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !step_n && order_sel) |=> cur_addr[BEAT_W-1:0] == (chk_start ^ chk_beat));  // R5

    AST_LINEAR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !step_n && !order_sel) |=> cur_addr[BEAT_W-1:0] == BEAT_W'(chk_start + chk_beat));  // R6

    AST_UPPER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        idle |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));  // R7

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);  // R8

endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .step_n       (step_n),
    .order_sel    (order_sel),
    .ext_addr     (ext_addr),
    .cur_addr     (cur_addr)
);

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
// Bench for burst_addr_seq: a behavioural reference model, compared after every clock edge.
module test_burst_addr_seq;

    localparam int AW = 17;
    localparam int NB = 4;
    localparam int BLEN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_strobe_n = 1'b1;
    logic          ctl_strobe_n = 1'b1;
    logic          step_n = 1'b1;
    logic [NB-1:0] bytewr_n = '1;
    logic          order_sel = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int m_addr = 0;
    int m_start = 0;
    int m_beat = 0;

    burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(BLEN), .NUM_BYTES(NB)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .step_n(step_n), .bytewr_n(bytewr_n), .order_sel(order_sel),
        .ext_addr(ext_addr), .cur_addr(cur_addr)
    );

    always #2 clk = ~clk;

    // One clock: drive at the falling edge, update the model at the rising edge, compare 1 ns later.
    task automatic tick(input bit rs, input bit cs, input bit ct, input bit st,
                        input logic [NB-1:0] bw, input bit md, input int addr, input string tag);
        string lbl;
        @(negedge clk);
        rst_n = rs; cpu_strobe_n = cs; ctl_strobe_n = ct; step_n = st;
        bytewr_n = bw; order_sel = md; ext_addr = AW'(addr);
        @(posedge clk);
        if (!rs) begin
            m_addr = 0; m_start = 0; m_beat = 0; lbl = "R8";
        end else if (!cs || !ct) begin
            m_addr = addr % (1 << AW); m_start = m_addr % BLEN; m_beat = 0; lbl = "R1";
        end else if (!st) begin
            int lo;
            m_beat = (m_beat + 1) % BLEN;
            lo = md ? (m_start ^ m_beat) : ((m_start + m_beat) % BLEN);
            m_addr = (m_addr / BLEN) * BLEN + lo;
            lbl = md ? "R5" : "R6";
        end else begin
            lbl = "R3";
        end
        if (tag != "") lbl = tag;
        #1;
        total++;
        if (int'(cur_addr) != m_addr) begin
            bad++;
            $display("FAIL %s: cur_addr actual=%0h expected=%0h", lbl, cur_addr, m_addr);
        end
    endtask

    // Watchdog: a hung run counts as one failed check and still prints the summary.
    initial begin
        #800000;
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset state, then stepping from start 0 in XOR order
        tick(0, 1, 1, 1, '1, 1, 0, "R8");
        tick(0, 0, 0, 0, '0, 1, 'h1abcd, "R8");
        tick(1, 1, 1, 0, '1, 1, 0, "R8");
        tick(1, 1, 1, 0, '1, 1, 0, "R8");
        // R1: load through the processor strobe, then XOR stepping (R5) and the wrap (R7)
        tick(1, 0, 1, 1, '1, 1, 'h12346, "R1");
        tick(1, 1, 1, 0, '1, 1, 0, "R5");
        tick(1, 1, 1, 0, '1, 1, 0, "R5");
        tick(1, 1, 1, 0, '1, 1, 0, "R5");
        tick(1, 1, 1, 0, '1, 1, 0, "R7");
        tick(1, 1, 1, 0, '1, 1, 0, "R7");
        // R1: load through the controller strobe, then linear stepping (R6) with the wrap (R7)
        tick(1, 1, 0, 1, '1, 0, 'h0fff7, "R1");
        tick(1, 1, 1, 0, '1, 0, 0, "R6");
        tick(1, 1, 1, 0, '1, 0, 0, "R7");
        tick(1, 1, 1, 0, '1, 0, 0, "R6");
        tick(1, 1, 1, 0, '1, 0, 0, "R7");
        // R4: write-style stepping with a byte-write strobe low
        tick(1, 1, 1, 0, 4'b1011, 0, 0, "R4");
        tick(1, 1, 1, 0, 4'b0000, 1, 0, "R4");
        // R2: a load collides with step and byte-write requests, on each strobe
        tick(1, 0, 1, 0, 4'b0000, 1, 'h00005, "R2");
        tick(1, 1, 0, 0, 4'b1110, 0, 'h1fffe, "R2");
        tick(1, 0, 0, 0, 4'b0101, 1, 'h0aaa9, "R2");
        // R9 and R3: byte-writes and mode changes with step high leave the address alone
        tick(1, 1, 1, 1, 4'b0000, 0, 'h11111, "R9");
        tick(1, 1, 1, 1, 4'b0110, 1, 'h22222, "R9");
        tick(1, 1, 1, 1, '1, 0, 'h33333, "R3");
        // R5/R6: a mode change in the middle of a burst
        tick(1, 0, 1, 1, '1, 1, 'h04443, "R1");
        tick(1, 1, 1, 0, '1, 0, 0, "R6");
        tick(1, 1, 1, 0, '1, 1, 0, "R5");
        tick(1, 1, 1, 0, '1, 0, 0, "R6");
        // Mixed random traffic (labels come from the model)
        for (int i = 0; i < 3000; i++) begin
            bit rs = ($urandom_range(0, 99) != 0);
            bit cs = ($urandom_range(0, 5) != 0);
            bit ct = ($urandom_range(0, 5) != 0);
            bit st = ($urandom_range(0, 2) == 0);
            bit md = ($urandom_range(0, 3) != 0);
            tick(rs, cs, ct, st, NB'($urandom), md, int'($urandom_range(0, (1 << AW) - 1)), "");
        end
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule